// File: doc/BRIEF.md
# CAN Controller Error and Status Register

This block is the 32-bit error and status word of a CAN controller, as seen by software on a simple register bus. The protocol engine feeds it one-cycle event pulses: a frame received correctly, a frame sent correctly, a new last-error code, a parity fault in the message memory, and a dominant bus level. It also feeds it level signals for bus-off, error warning, error passive and the local power-down acknowledge. The event bits stay set until software reads the word. The level bits show the current state of those inputs.

A read has side effects. The value returned is the one held before the read. In the same cycle the read clears the event flags and sets the 3-bit error-code field to the "no change" code 111. If an event arrives in the same cycle as a read, the event wins. Writes are accepted on the bus but change nothing.

Top module: `can_err_stat_reg`

## Requirements
- R1: Field layout of the read word: bits 2:0 error code, bit 3 transmit-OK, bit 4 receive-OK, bit 5 error-passive, bit 6 error-warning, bit 7 bus-off, bit 8 parity error, bit 9 wake-up pending, bit 10 power-down acknowledge. Bits 31:11 always read as 0.
- R2: After reset the error code is 111, all event flags are 0, and `bus_rdata` is 0.
- R3: A read is `bus_sel`=1, `bus_wr`=0 and `bus_addr`=REG_OFS. One cycle after the read, `bus_rdata` holds the word as it was before that read's side effects. `bus_rdata` keeps its value until the next read.
- R4: A read with no error-code event in the same cycle sets the error-code field to 111.
- R5: An error-code event (`ev_lec_vld`=1) loads `ev_lec` into the field, whatever the field held before.
- R6: A pulse on `ev_tx_ok` or `ev_rx_ok` sets its flag. The flag stays set until a read clears it.
- R7: A pulse on `ev_parity_err` sets the parity flag. The flag stays set until a read clears it.
- R8: A dominant bus level while `st_pd_ack`=1 sets the wake-up flag. A dominant level while `st_pd_ack`=0 has no effect.
- R9: When a set event and a clearing read fall in the same cycle, the bit is 1 afterwards, and the read returns the old value.
- R10: Bits 5, 6, 7 and 10 return the levels of `st_epass`, `st_ewarn`, `st_boff` and `st_pd_ack` in the read cycle. They are not stored as flags.
- R11: Writes (`bus_wr`=1) change no bit of the word.
- R12: An access at any address other than REG_OFS has no read side effects and leaves `bus_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 32 | Write data (ignored) |
| bus_rdata | output | 32 | Registered read data |
| ev_tx_ok | input | 1 | Frame transmitted pulse |
| ev_rx_ok | input | 1 | Frame received pulse |
| ev_lec_vld | input | 1 | New error code pulse |
| ev_lec | input | 3 | Error code value |
| ev_parity_err | input | 1 | Message memory parity fault pulse |
| bus_dominant | input | 1 | Bus seen dominant |
| st_boff | input | 1 | Bus-off level |
| st_ewarn | input | 1 | Error warning level |
| st_epass | input | 1 | Error passive level |
| st_pd_ack | input | 1 | Local power-down acknowledge level |

## Verification
The bench builds the block with ADDR_W=4 and REG_OFS=4'h4. With those values, an access at a neighbouring offset tests that a stray address neither clears flags nor moves the read data. Directed sequences cover these cases:
- an event colliding with a read in the same cycle;
- an error code replaced before it is read;
- a dominant bus level with and without the power-down acknowledge.

A random phase then mixes all inputs against a behavioural model.

// File: rtl/can_esr_pkg.sv
package can_esr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEC_W  = 3;
  localparam logic [LEC_W-1:0] LEC_NOCHG = '1;

  localparam int unsigned POS_TX    = 3;
  localparam int unsigned POS_RX    = 4;
  localparam int unsigned POS_EPASS = 5;
  localparam int unsigned POS_EWARN = 6;
  localparam int unsigned POS_BOFF  = 7;
  localparam int unsigned POS_PER   = 8;
  localparam int unsigned POS_WAKE  = 9;
  localparam int unsigned POS_PDA   = 10;
  localparam int unsigned USED_W    = 11;

  localparam int unsigned EVI_TX   = 0;
  localparam int unsigned EVI_RX   = 1;
  localparam int unsigned EVI_PER  = 2;
  localparam int unsigned EVI_WAKE = 3;
  localparam int unsigned N_EV     = 4;

  typedef struct packed {
    logic pda;
    logic boff;
    logic ewarn;
    logic epass;
  } live_t;
endpackage

// File: rtl/can_esr_rst_sync.sv
module can_esr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/can_esr_sticky.sv
module can_esr_sticky #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  logic [N-1:0] nxt;
  logic [N-1:0] en;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      en[g]  = set[g] | clr;
      nxt[g] = set[g] | (q[g] & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= 1'b0;
      else if (en[g]) q[g] <= nxt[g];
    end

    AST_STICKY_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> q[g]); // R9
    AST_STICKY_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set[g]) |=> !q[g]); // R6
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set[g]) |=> $stable(q[g])); // R6
  end
endmodule

// File: rtl/can_esr_code.sv
module can_esr_code #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic         vld,
  input  logic [W-1:0] code,
  output logic [W-1:0] lec
);
  logic [W-1:0] lec_nxt;
  logic         lec_en;

  always_comb begin
    lec_en  = vld | rd;
    lec_nxt = vld ? code : {W{1'b1}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lec <= {W{1'b1}};
    else if (lec_en) lec <= lec_nxt;
  end

  AST_LEC_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> (lec == $past(code))); // R5
  AST_LEC_RD_NOCHG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !vld) |=> (lec == {W{1'b1}})); // R4
  AST_LEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !vld) |=> $stable(lec)); // R11
endmodule

// File: rtl/can_esr_bus.sv
module can_esr_bus #(
  parameter int unsigned ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] REG_OFS = '0,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] image,
  output logic              rd_stb,
  output logic [DATA_W-1:0] rdata
);
  logic hit;

  always_comb begin
    hit    = (addr == REG_OFS);
    rd_stb = sel & ~wr & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_stb) rdata <= image;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rdata)); // R3
  AST_RDATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (rdata == $past(image))); // R3
endmodule

// File: rtl/can_err_stat_reg.sv
module can_err_stat_reg
  import can_esr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] REG_OFS = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_tx_ok,
  input  logic              ev_rx_ok,
  input  logic              ev_lec_vld,
  input  logic [2:0]        ev_lec,
  input  logic              ev_parity_err,
  input  logic              bus_dominant,
  input  logic              st_boff,
  input  logic              st_ewarn,
  input  logic              st_epass,
  input  logic              st_pd_ack
);
  logic              rst_sync_n;
  logic              rd_stb;
  logic [N_EV-1:0]   ev_set;
  logic [N_EV-1:0]   flags;
  logic [LEC_W-1:0]  lec;
  live_t             live;
  logic [DATA_W-1:0] image;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  can_esr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EVI_TX]   = ev_tx_ok;
    ev_set[EVI_RX]   = ev_rx_ok;
    ev_set[EVI_PER]  = ev_parity_err;
    ev_set[EVI_WAKE] = bus_dominant & st_pd_ack;
    live.pda         = st_pd_ack;
    live.boff        = st_boff;
    live.ewarn       = st_ewarn;
    live.epass       = st_epass;
  end

  can_esr_sticky #(.N(N_EV)) u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (rd_stb),
    .set   (ev_set),
    .q     (flags)
  );

  can_esr_code #(.W(LEC_W)) u_code (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rd    (rd_stb),
    .vld   (ev_lec_vld),
    .code  (ev_lec),
    .lec   (lec)
  );

  always_comb begin
    image                = '0;
    image[LEC_W-1:0]     = lec;
    image[POS_TX]        = flags[EVI_TX];
    image[POS_RX]        = flags[EVI_RX];
    image[POS_EPASS]     = live.epass;
    image[POS_EWARN]     = live.ewarn;
    image[POS_BOFF]      = live.boff;
    image[POS_PER]       = flags[EVI_PER];
    image[POS_WAKE]      = flags[EVI_WAKE];
    image[POS_PDA]       = live.pda;
  end

  can_esr_bus #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS), .DATA_W(DATA_W)) u_bus (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .image  (image),
    .rd_stb (rd_stb),
    .rdata  (bus_rdata)
  );

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[DATA_W-1:USED_W] == '0); // R1
  AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_dominant && st_pd_ack) |=> flags[EVI_WAKE]); // R8
  AST_PER_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_parity_err |=> flags[EVI_PER]); // R7
  AST_LIVE_BOFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_stb |=> (bus_rdata[POS_BOFF] == $past(st_boff))); // R10
  AST_WRITE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && bus_wr && flags[EVI_TX]) |=> flags[EVI_TX]); // R11
endmodule

// File: tb/tb_can_err_stat_reg.sv
`timescale 1ns/1ps
module tb_can_err_stat_reg;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] OFS = 4'h4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ev_tx_ok, ev_rx_ok, ev_lec_vld, ev_parity_err, bus_dominant;
  logic [2:0]  ev_lec;
  logic        st_boff, st_ewarn, st_epass, st_pd_ack;

  int nchk = 0;
  int nerr = 0;
  bit cmp_en = 0;
  bit done = 0;

  // reference model state
  int          m_lec;
  bit          m_tx, m_rx, m_per, m_wake;
  logic [31:0] m_rdata;

  always #2.5 clk = ~clk;

  can_err_stat_reg #(.ADDR_W(AW), .REG_OFS(OFS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok), .ev_lec_vld(ev_lec_vld),
    .ev_lec(ev_lec), .ev_parity_err(ev_parity_err), .bus_dominant(bus_dominant),
    .st_boff(st_boff), .st_ewarn(st_ewarn), .st_epass(st_epass), .st_pd_ack(st_pd_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of the word, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lec = 7; m_tx = 0; m_rx = 0; m_per = 0; m_wake = 0; m_rdata = 0;
    end else begin
      bit rd;
      rd = bus_sel && !bus_wr && (bus_addr == OFS);
      if (rd) begin
        m_rdata = 32'(m_lec) + (m_tx ? 32'h8 : 0) + (m_rx ? 32'h10 : 0)
                + (st_epass ? 32'h20 : 0) + (st_ewarn ? 32'h40 : 0)
                + (st_boff ? 32'h80 : 0) + (m_per ? 32'h100 : 0)
                + (m_wake ? 32'h200 : 0) + (st_pd_ack ? 32'h400 : 0);
      end
      if (ev_lec_vld) m_lec = int'(ev_lec);
      else if (rd)    m_lec = 7;
      m_tx   = ev_tx_ok || (m_tx && !rd);
      m_rx   = ev_rx_ok || (m_rx && !rd);
      m_per  = ev_parity_err || (m_per && !rd);
      m_wake = (bus_dominant && st_pd_ack) || (m_wake && !rd);
    end
  end

  always @(negedge clk) begin
    if (cmp_en) check("R3 model", bus_rdata, m_rdata);
  end

  task automatic idle();
    bus_sel = 0; bus_wr = 0; bus_addr = OFS; bus_wdata = 0;
    ev_tx_ok = 0; ev_rx_ok = 0; ev_lec_vld = 0; ev_lec = 0;
    ev_parity_err = 0; bus_dominant = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_read(output logic [31:0] v);
    bus_sel = 1; bus_wr = 0; bus_addr = OFS;
    @(negedge clk);
    idle();
    v = bus_rdata;
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle();
    st_boff = 0; st_ewarn = 0; st_epass = 0; st_pd_ack = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R2 rdata reset", bus_rdata, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_en = 1;

    do_read(v); check("R2 R1 first read", v, 32'h7);
    // R6 transmit flag
    ev_tx_ok = 1; step();
    do_read(v); check("R6 tx set", v, 32'hF);
    do_read(v); check("R6 tx cleared", v, 32'h7);
    // R5 receive plus code, then R4
    ev_rx_ok = 1; ev_lec_vld = 1; ev_lec = 3; step();
    do_read(v); check("R5 rx and code", v, 32'h13);
    do_read(v); check("R4 code to 111", v, 32'h7);
    ev_lec_vld = 1; ev_lec = 2; step();
    ev_lec_vld = 1; ev_lec = 5; step();
    do_read(v); check("R5 overwrite", v, 32'h5);
    // R3 hold
    repeat (3) step();
    check("R3 hold", bus_rdata, 32'h5);
    // R7 parity
    ev_parity_err = 1; step();
    repeat (2) step();
    do_read(v); check("R7 parity held", v, 32'h107);
    do_read(v); check("R7 parity cleared", v, 32'h7);
    // R8 wake
    bus_dominant = 1; step();
    do_read(v); check("R8 no pd ack", v, 32'h7);
    st_pd_ack = 1; step();
    bus_dominant = 1; step();
    do_read(v); check("R8 R10 wake and pda", v, 32'h607);
    st_pd_ack = 0; step();
    do_read(v); check("R8 wake cleared", v, 32'h7);
    // R10 live levels
    st_boff = 1; st_ewarn = 1; st_epass = 1; step();
    do_read(v); check("R10 live", v, 32'hE7);
    st_boff = 0; st_ewarn = 0; st_epass = 0; step();
    // R11 writes
    ev_tx_ok = 1; step();
    bus_sel = 1; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF; step();
    check("R11 rdata after write", bus_rdata, 32'hE7);
    do_read(v); check("R11 write ignored", v, 32'hF);
    // R12 other address
    ev_tx_ok = 1; step();
    bus_sel = 1; bus_addr = OFS ^ 4'h1; step();
    check("R12 rdata unchanged", bus_rdata, 32'hF);
    do_read(v); check("R12 no side effect", v, 32'hF);
    // R9 collisions
    bus_sel = 1; ev_tx_ok = 1; @(negedge clk); idle(); v = bus_rdata;
    check("R9 old value", v, 32'h7);
    do_read(v); check("R9 set wins", v, 32'hF);
    bus_sel = 1; ev_lec_vld = 1; ev_lec = 4; @(negedge clk); idle(); v = bus_rdata;
    check("R9 code old", v, 32'h7);
    do_read(v); check("R9 code wins", v, 32'h4);

    // random mix against model
    for (int i = 0; i < 2000; i++) begin
      bus_sel       = ($urandom_range(0, 2) == 0);
      bus_wr        = ($urandom_range(0, 3) == 0);
      bus_addr      = ($urandom_range(0, 4) == 0) ? AW'($urandom) : OFS;
      bus_wdata     = $urandom;
      ev_tx_ok      = ($urandom_range(0, 5) == 0);
      ev_rx_ok      = ($urandom_range(0, 5) == 0);
      ev_lec_vld    = ($urandom_range(0, 4) == 0);
      ev_lec        = 3'($urandom);
      ev_parity_err = ($urandom_range(0, 9) == 0);
      bus_dominant  = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) st_pd_ack = ~st_pd_ack;
      st_boff  = ($urandom_range(0, 3) == 0);
      st_ewarn = ($urandom_range(0, 3) == 0);
      st_epass = ($urandom_range(0, 3) == 0);
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule